// File: doc/BRIEF.md
# Auxiliary IO and Power-Fail Controller

This block is a small register bank that sits behind a simple synchronous bus port and collects a workstation's miscellaneous control functions. It provides byte registers for configuration, two auxiliary controls, diagnostics and modem control. It also has a 16-bit diagnostic LED register and a system control register. Every register is selected by the upper address field. Reads are combinational from the address, and writes take effect on the clock edge where the write strobe is high.

The block watches an asynchronous power-failing input. A change on that input, seen after a two-flop synchroniser, sets or clears a sticky power-fail flag in the second auxiliary register. The flag is set only while the power interrupt is enabled in the configuration register. A registered, level-sensitive interrupt output reports the flag gated by that enable. Software can drop the flag with a clear bit and can command power-off.

Writes to certain locations produce single-cycle request pulses for shutdown, system reset and CPU halt, one clock after the write. Some registers are cleared by reset and others deliberately keep their contents across it.

Top module: `auxio_ctrl`

## Requirements
- R1: The register is chosen by address bits 27:16: 0x160 LED, 0x180 config, 0x190 aux-1, 0x191 aux-2, 0x1A0 diagnostic, 0x1B0 modem, 0x1F0 system control. An address that selects nothing reads 0 and a write to it changes no register.
- R2: `irq_out` is registered. One clock after the aux-2 power-fail flag (bit 5) and the config enable (bit 3) are both 1, it is 1. Otherwise it is 0 one clock later.
- R3: `pwr_fail_in` passes through two synchronising flops. When the synchronised level changes, the flag becomes 1 if the level is high and config bit 3 is set, and 0 in every other case. Without such a change, the flag changes only through an aux-2 write.
- R4: An aux-2 write stores wdata bit 0 as the power-off bit and keeps the flag. If wdata bit 1 is 1, the flag is cleared. Bit 1 and all other bits always read as 0.
- R5: An aux-2 write with wdata bit 0 set gives a one-cycle `shutdown_req` pulse in the cycle after the write.
- R6: Reset clears config, aux-1, aux-2 and modem. Diagnostic and system control keep their values.
- R7: System control is active only when address bits 1:0 are 0. A write there with bit 0 set makes it read 0x00000002 and pulses `sysreset_req` for one cycle after the write. A write with bit 0 clear changes nothing. Offsets 1 to 3 read 0.
- R8: The LED register is 16 bits wide at even addresses (address bit 0 = 0). An odd address reads 0 and ignores writes.
- R9: A write to the address `PM_ADDR` pulses `halt_req` for one cycle after the write. A read from that address returns 0.
- R10: Config, aux-1, diagnostic and modem registers read back the low byte last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 28 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| pwr_fail_in | input | 1 | Asynchronous power-failing indication |
| irq_out | output | 1 | Power-fail interrupt, level |
| shutdown_req | output | 1 | Power-off request pulse |
| sysreset_req | output | 1 | System reset request pulse |
| halt_req | output | 1 | CPU halt request pulse |

## Verification
The power-fail path is driven with several sequences. The input rises with the interrupt enabled and again with it disabled; the enable is then turned on without any input change. The flag is cleared by software while the input stays high, and the input then falls. These sequences separate an event-driven flag from one that simply follows the input level. Disabling the enable while the flag is set shows that only the interrupt drops and the flag stays. Aux-2 writes are made with each combination of the clear and power-off bits, and reset is pulsed after the diagnostic and system control registers have been loaded.

// File: rtl/auxio_pkg.sv
package auxio_pkg;
  localparam int SEL_LSB = 16;
  localparam int SEL_W   = 12;

  localparam logic [SEL_W-1:0] SEL_LED  = 12'h160;
  localparam logic [SEL_W-1:0] SEL_CFG  = 12'h180;
  localparam logic [SEL_W-1:0] SEL_AUX1 = 12'h190;
  localparam logic [SEL_W-1:0] SEL_AUX2 = 12'h191;
  localparam logic [SEL_W-1:0] SEL_DIAG = 12'h1A0;
  localparam logic [SEL_W-1:0] SEL_MDM  = 12'h1B0;
  localparam logic [SEL_W-1:0] SEL_SYS  = 12'h1F0;

  localparam int CFG_PIE_BIT  = 3;
  localparam int AUX2_PF_BIT  = 5;
  localparam int AUX2_PO_BIT  = 0;
  localparam int AUX2_CLR_BIT = 1;

  typedef enum logic [3:0] {
    RG_NONE, RG_LED, RG_CFG, RG_AUX1, RG_AUX2,
    RG_DIAG, RG_MDM, RG_SYS, RG_PM
  } rgn_e;

  // flag after an aux-2 write: kept unless the clear bit is written
  function automatic logic pf_after_write(input logic pf, input logic clr);
    return pf & ~clr;
  endfunction

  // flag after a change on the synchronised input
  function automatic logic pf_after_event(input logic lvl, input logic en);
    return lvl & en;
  endfunction

  function automatic logic irq_cond(input logic pf, input logic en);
    return pf & en;
  endfunction

  function automatic logic [7:0] aux2_image(input logic pf, input logic po);
    logic [7:0] v;
    v = '0;
    v[AUX2_PF_BIT] = pf;
    v[AUX2_PO_BIT] = po;
    return v;
  endfunction
endpackage

// File: rtl/auxio_sync.sv
module auxio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/auxio_decode.sv
module auxio_decode
  import auxio_pkg::*;
#(
  parameter int                ADDR_W  = 28,
  parameter logic [ADDR_W-1:0] PM_ADDR = 28'h0A0_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              rgn
);
  localparam int HI = SEL_LSB + SEL_W - 1;

  logic [SEL_W-1:0] sel;
  assign sel = addr[HI:SEL_LSB];

  always_comb begin
    unique case (sel)
      SEL_LED:  rgn = RG_LED;
      SEL_CFG:  rgn = RG_CFG;
      SEL_AUX1: rgn = RG_AUX1;
      SEL_AUX2: rgn = RG_AUX2;
      SEL_DIAG: rgn = RG_DIAG;
      SEL_MDM:  rgn = RG_MDM;
      SEL_SYS:  rgn = RG_SYS;
      default:  rgn = (addr == PM_ADDR) ? RG_PM : RG_NONE;
    endcase
  end
endmodule

// File: rtl/auxio_pwr.sv
module auxio_pwr
  import auxio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail_in,
  input  logic cfg_pie,
  input  logic aux2_wr,
  input  logic wr_clr,
  input  logic wr_po,
  output logic pf_flag,
  output logic po_bit,
  output logic irq
);
  logic lvl_sync, lvl_prev, lvl_change;

  auxio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(pwr_fail_in),
    .q_sync (lvl_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl_sync;
  end

  assign lvl_change = lvl_sync ^ lvl_prev;

  // an input change takes precedence over a same-cycle software clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_flag <= 1'b0;
      po_bit  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (lvl_change)   pf_flag <= pf_after_event(lvl_sync, cfg_pie);
      else if (aux2_wr) pf_flag <= pf_after_write(pf_flag, wr_clr);
      if (aux2_wr)      po_bit  <= wr_po;
      irq <= irq_cond(pf_flag, cfg_pie);
    end
  end
endmodule

// File: rtl/auxio_ctrl.sv
module auxio_ctrl
  import auxio_pkg::*;
#(
  parameter int                ADDR_W  = 28,
  parameter int                DATA_W  = 32,
  parameter int                LED_W   = 16,
  parameter logic [ADDR_W-1:0] PM_ADDR = 28'h0A0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pwr_fail_in,
  output logic              irq_out,
  output logic              shutdown_req,
  output logic              sysreset_req,
  output logic              halt_req
);
  localparam int BYTE_W = 8;

  rgn_e rgn;
  logic [BYTE_W-1:0] cfg_q, aux1_q, diag_q, mdm_q;
  logic [LED_W-1:0]  led_q;
  logic              sysrst_flag_q;
  logic              pf_flag, po_bit, cfg_pie;
  logic              led_hit, sys_hit;
  logic              wr_aux2, wr_sys_go, wr_pm;

  auxio_decode #(.ADDR_W(ADDR_W), .PM_ADDR(PM_ADDR)) u_dec (
    .addr(addr),
    .rgn (rgn)
  );

  assign led_hit   = (rgn == RG_LED) && (addr[0] == 1'b0);
  assign sys_hit   = (rgn == RG_SYS) && (addr[1:0] == 2'b00);
  assign wr_aux2   = wr_en && (rgn == RG_AUX2);
  assign wr_sys_go = wr_en && sys_hit && wdata[0];
  assign wr_pm     = wr_en && (rgn == RG_PM);
  assign cfg_pie   = cfg_q[CFG_PIE_BIT];

  auxio_pwr u_pwr (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_fail_in(pwr_fail_in),
    .cfg_pie    (cfg_pie),
    .aux2_wr    (wr_aux2),
    .wr_clr     (wdata[AUX2_CLR_BIT]),
    .wr_po      (wdata[AUX2_PO_BIT]),
    .pf_flag    (pf_flag),
    .po_bit     (po_bit),
    .irq        (irq_out)
  );

  // registers cleared by reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      aux1_q <= '0;
      mdm_q  <= '0;
    end else if (wr_en) begin
      if (rgn == RG_CFG)  cfg_q  <= wdata[BYTE_W-1:0];
      if (rgn == RG_AUX1) aux1_q <= wdata[BYTE_W-1:0];
      if (rgn == RG_MDM)  mdm_q  <= wdata[BYTE_W-1:0];
    end
  end

  // registers that survive reset
  always_ff @(posedge clk) begin
    if (wr_en && (rgn == RG_DIAG)) diag_q <= wdata[BYTE_W-1:0];
    if (wr_en && led_hit)          led_q  <= wdata[LED_W-1:0];
    if (wr_sys_go)                 sysrst_flag_q <= 1'b1;
  end

  // request pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shutdown_req <= 1'b0;
      sysreset_req <= 1'b0;
      halt_req     <= 1'b0;
    end else begin
      shutdown_req <= wr_aux2 && wdata[AUX2_PO_BIT];
      sysreset_req <= wr_sys_go;
      halt_req     <= wr_pm;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (rgn)
      RG_CFG:  rdata[BYTE_W-1:0] = cfg_q;
      RG_AUX1: rdata[BYTE_W-1:0] = aux1_q;
      RG_AUX2: rdata[BYTE_W-1:0] = aux2_image(pf_flag, po_bit);
      RG_DIAG: rdata[BYTE_W-1:0] = diag_q;
      RG_MDM:  rdata[BYTE_W-1:0] = mdm_q;
      RG_LED:  if (led_hit) rdata[LED_W-1:0] = led_q;
      RG_SYS:  if (sys_hit) rdata[1] = sysrst_flag_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/auxio_ctrl_chk.sv
module auxio_ctrl_chk
  import auxio_pkg::*;
#(
  parameter int                ADDR_W  = 28,
  parameter int                DATA_W  = 32,
  parameter logic [ADDR_W-1:0] PM_ADDR = 28'h0A0_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq_out,
  input logic              shutdown_req,
  input logic              sysreset_req,
  input logic              halt_req,
  input logic              pf_flag,
  input logic              cfg_pie
);
  logic [SEL_W-1:0] sel;
  assign sel = addr[SEL_LSB+SEL_W-1:SEL_LSB];

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(pf_flag && cfg_pie))); // R2

  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_flag) |-> $past(cfg_pie)); // R3

  AST_SHUTDOWN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_AUX2 && wdata[0]) |=> shutdown_req); // R5

  AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(wr_en)); // R5

  AST_SYSRESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_SYS && addr[1:0] == 2'b00 && wdata[0]) |=> sysreset_req); // R7

  AST_HALT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PM_ADDR) |=> halt_req); // R9

  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(wr_en)); // R9
endmodule

bind auxio_ctrl auxio_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PM_ADDR(PM_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .addr        (addr),
  .wdata       (wdata),
  .irq_out     (irq_out),
  .shutdown_req(shutdown_req),
  .sysreset_req(sysreset_req),
  .halt_req    (halt_req),
  .pf_flag     (pf_flag),
  .cfg_pie     (cfg_pie)
);

// File: tb/auxio_ctrl_test.sv
module auxio_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [27:0] PM = 28'h0A0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [27:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwr_fail_in = 1'b0;
  logic        irq_out, shutdown_req, sysreset_req, halt_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic p_sd, p_sr, p_ht;

  always #(CLK_PERIOD/2) clk = ~clk;

  auxio_ctrl #(.PM_ADDR(PM)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwr_fail_in(pwr_fail_in), .irq_out(irq_out),
    .shutdown_req(shutdown_req), .sysreset_req(sysreset_req), .halt_req(halt_req)
  );

  function automatic logic [27:0] at(input logic [11:0] sel, input logic [15:0] lo);
    return {sel, lo};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [27:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    p_sd = shutdown_req; p_sr = sysreset_req; p_ht = halt_req;
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [27:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(at(12'h180, 0), d); check("R6 cfg after reset", d, 0);
    rd(at(12'h190, 0), d); check("R6 aux1 after reset", d, 0);
    rd(at(12'h191, 0), d); check("R6 aux2 after reset", d, 0);
    rd(at(12'h1B0, 0), d); check("R6 modem after reset", d, 0);
    check("R2 irq after reset", {31'b0, irq_out}, 0);
    check("R5 no pulses after reset", {29'b0, shutdown_req, sysreset_req, halt_req}, 0);
  endtask

  task automatic t_byte_regs();
    logic [31:0] d;
    wr(at(12'h180, 16'h0040), 32'hFFFF_FF37);
    wr(at(12'h190, 0), 32'h0000_00A5);
    wr(at(12'h1A0, 0), 32'h0000_005A);
    wr(at(12'h1B0, 0), 32'h1234_56C3);
    rd(at(12'h180, 0), d); check("R10 cfg readback", d, 32'h37);
    rd(at(12'h190, 0), d); check("R10 aux1 readback", d, 32'hA5);
    rd(at(12'h1A0, 0), d); check("R10 diag readback", d, 32'h5A);
    rd(at(12'h1B0, 0), d); check("R10 modem readback", d, 32'hC3);
    wr(at(12'h180, 0), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(at(12'h170, 0), 32'hFF);
    wr(at(12'h181, 0), 32'hFF);
    rd(at(12'h170, 0), d); check("R1 unmapped read", d, 0);
    rd(at(12'h181, 0), d); check("R1 neighbour read", d, 0);
    rd(at(12'h180, 0), d); check("R1 cfg untouched", d, 0);
    rd(at(12'h190, 0), d); check("R1 aux1 untouched", d, 32'hA5);
  endtask

  task automatic t_aux2();
    logic [31:0] d;
    wr(at(12'h191, 0), 32'hFF_FE);
    check("R5 no shutdown when bit0 clear", {31'b0, p_sd}, 0);
    rd(at(12'h191, 0), d); check("R4 only bit0 stored", d, 0);
    wr(at(12'h191, 0), 32'h0000_0001);
    check("R5 shutdown pulse", {31'b0, p_sd}, 1);
    @(negedge clk);
    check("R5 shutdown is single cycle", {31'b0, shutdown_req}, 0);
    rd(at(12'h191, 0), d); check("R4 power-off bit reads", d, 32'h01);
    wr(at(12'h191, 0), 32'h0000_0003);
    rd(at(12'h191, 0), d); check("R4 clear bit reads 0", d, 32'h01);
    wr(at(12'h191, 0), 0);
  endtask

  task automatic t_powerfail();
    logic [31:0] d;
    wr(at(12'h180, 0), 32'h08);
    @(negedge clk); pwr_fail_in = 1'b1;
    idle(6);
    rd(at(12'h191, 0), d); check("R3 flag set on rise", d, 32'h20);
    check("R2 irq high", {31'b0, irq_out}, 1);
    wr(at(12'h180, 0), 32'h00);
    idle(2);
    check("R2 irq drops with enable", {31'b0, irq_out}, 0);
    rd(at(12'h191, 0), d); check("R3 flag kept without event", d, 32'h20);
    wr(at(12'h180, 0), 32'h08);
    idle(2);
    check("R2 irq back with enable", {31'b0, irq_out}, 1);
    wr(at(12'h191, 0), 32'h02);
    idle(2);
    rd(at(12'h191, 0), d); check("R4 clear drops flag", d, 0);
    check("R2 irq low after clear", {31'b0, irq_out}, 0);
    idle(4);
    rd(at(12'h191, 0), d); check("R3 input still high, no reset of flag", d, 0);
    @(negedge clk); pwr_fail_in = 1'b0;
    idle(6);
    rd(at(12'h191, 0), d); check("R3 fall clears", d, 0);
    wr(at(12'h180, 0), 32'h00);
    @(negedge clk); pwr_fail_in = 1'b1;
    idle(6);
    rd(at(12'h191, 0), d); check("R3 no set when disabled", d, 0);
    wr(at(12'h180, 0), 32'h08);
    idle(4);
    rd(at(12'h191, 0), d); check("R3 enabling alone sets nothing", d, 0);
    check("R2 irq stays low", {31'b0, irq_out}, 0);
    @(negedge clk); pwr_fail_in = 1'b0;
    idle(6);
    @(negedge clk); pwr_fail_in = 1'b1;
    idle(6);
    check("R2 irq on new event", {31'b0, irq_out}, 1);
    @(negedge clk); pwr_fail_in = 1'b0;
    idle(6);
    rd(at(12'h191, 0), d); check("R3 fall with enable clears", d, 0);
    wr(at(12'h180, 0), 0);
  endtask

  task automatic t_sysctrl();
    logic [31:0] d;
    wr(at(12'h1F0, 16'h0001), 32'h1);
    check("R7 offset1 no pulse", {31'b0, p_sr}, 0);
    wr(at(12'h1F0, 0), 32'h1);
    check("R7 reset pulse", {31'b0, p_sr}, 1);
    rd(at(12'h1F0, 0), d); check("R7 status reads", d, 32'h2);
    wr(at(12'h1F0, 0), 32'hFFFF_FFFE);
    check("R7 bit0 clear no pulse", {31'b0, p_sr}, 0);
    rd(at(12'h1F0, 0), d); check("R7 bit0 clear no change", d, 32'h2);
    rd(at(12'h1F0, 16'h0003), d); check("R7 offset3 reads zero", d, 0);
  endtask

  task automatic t_led();
    logic [31:0] d;
    wr(at(12'h160, 0), 32'hABCD_1234);
    wr(at(12'h160, 16'h0001), 32'h0000_FFFF);
    rd(at(12'h160, 0), d); check("R8 led 16 bit", d, 32'h1234);
    rd(at(12'h160, 16'h0001), d); check("R8 odd reads zero", d, 0);
  endtask

  task automatic t_pm();
    logic [31:0] d;
    wr(PM, 32'h5);
    check("R9 halt pulse", {31'b0, p_ht}, 1);
    @(negedge clk);
    check("R9 halt single cycle", {31'b0, halt_req}, 0);
    rd(PM, d); check("R9 pm read zero", d, 0);
    wr(PM + 28'h4, 32'h5);
    check("R1 near pm no halt", {31'b0, p_ht}, 0);
  endtask

  task automatic t_reset_keep();
    logic [31:0] d;
    wr(at(12'h190, 0), 32'h11);
    do_reset();
    rd(at(12'h1A0, 0), d); check("R6 diag kept", d, 32'h5A);
    rd(at(12'h1F0, 0), d); check("R6 sysctrl kept", d, 32'h2);
    rd(at(12'h190, 0), d); check("R6 aux1 cleared", d, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_byte_regs();
    t_unmapped();
    t_aux2();
    t_powerfail();
    t_sysctrl();
    t_led();
    t_pm();
    t_reset_keep();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule